// File: doc/BRIEF.md
# Multi-line transmit DMA scheduler

This block is the transmit half of a sixteen-line asynchronous multiplexer. Each line owns an address pointer and a byte counter. All sixteen pairs are reached through one shared register window, and a line-select field in the control register picks which pair the window shows. The counter holds the negative of the number of bytes still to send and climbs toward zero.

Software starts a line by setting its bit in the active mask. The block picks among active lines in turn and fetches one byte per turn over a valid/ready memory read port. It hands each byte to the line over a valid/ready transmit handshake. When a line's counter reaches zero, the hardware clears that line's active bit and raises a transmit interrupt flag. A read error on the memory port also ends the line and latches a bad-memory flag. A break mask forces chosen lines to the spacing level. A master-clear bit wipes all state.

Back-pressure has two parts. The memory request holds valid, with a stable address, until ready is seen. The transmit output holds valid, with a stable line number and data byte, until `tx_ready[tx_line]` is high. Only lines whose `tx_ready` is high take part in arbitration, so a stalled line never blocks the others. Memory responses are always accepted, and the block keeps at most one request outstanding.

Top module: `mux_tx_dma`

## Requirements
- R1: Bits 3:0 of the control register (offset 0) select the line whose address (offset 1) and count (offset 2) registers are read and written. All registers reset to zero.
- R2: For an active line, each byte is read from the line's current address and delivered on the transmit port with `tx_line` set to that line. After each byte, the address and the count each increase by one. When the count reaches zero, the line's bit in the active mask (offset 3, bit N for line N) clears, and the address then reads start plus the number of bytes sent.
- R3: A write to the active mask only sets bits. Writing 0 to a bit leaves it unchanged.
- R4: Lines compete only while both their active bit and their `tx_ready` are high. One byte is sent per grant, and grants rotate starting from the line after the one last granted. After a master clear, line 0 comes first in that rotation.
- R5: Writing 16'hFFFF to the count of an active line ends that line after at most one more byte.
- R6: Bit 15 of the control register sets whenever a line retires. `irq` equals bit 15 AND bit 13 (the interrupt enable). A control write with bit 15 at 0 clears the flag, and a write with bit 15 at 1 leaves it as it is.
- R7: A memory response with its error flag set does four things: it sets control bit 10, clears the line's active bit, sets bit 15, and sends no byte. The line's address and count keep their values from before the failing fetch. Writing 1 to control bit 8 clears bit 10.
- R8: Writing 1 to control bit 11 (master clear) zeroes every address, count, active bit, break bit and control field. Bits 11 and 8 always read as 0.
- R9: The break register (offset 4, bit N for line N) drives `line_break` directly and reads back as written.
- R10: `mem_req_valid` stays high with `mem_req_addr` stable until `mem_req_ready`. `tx_valid` stays high with `tx_line` and `tx_data` stable until `tx_ready[tx_line]`.
- R11: A line granted while its count is already zero retires at once, with no memory request and no byte sent, and sets bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register offset |
| csr_wdata | input | 16 | Register write data |
| csr_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Transmit interrupt |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request ready |
| mem_req_addr | output | 16 | Byte address of the request |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 8 | Memory response byte |
| mem_rsp_err | input | 1 | Memory response error (address not present) |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 16 | Per-line ready to take a byte |
| tx_line | output | 4 | Line the byte belongs to |
| tx_data | output | 8 | Byte to transmit |
| line_break | output | 16 | Per-line forced-spacing control |

## Verification
The hardest state to reach from the ports is an abort that lands while the line's byte is still in flight. The count must be rewritten between the grant and the delivery, which is only a few cycles. The bench reaches this state by holding `mem_req_ready` low. This parks the engine on its request for the line, and the bench then writes the count and releases the memory. It checks that exactly one byte follows. While the engine is parked, the bench also confirms that the request address holds steady.

// File: rtl/mtd_pkg.sv
package mtd_pkg;
  localparam int REG_W = 16;

  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_ADDR = 3'd1;
  localparam logic [2:0] OFF_CNT  = 3'd2;
  localparam logic [2:0] OFF_ACT  = 3'd3;
  localparam logic [2:0] OFF_BRK  = 3'd4;

  localparam int B_TXF   = 15;
  localparam int B_TXIE  = 13;
  localparam int B_MCLR  = 11;
  localparam int B_NXM   = 10;
  localparam int B_NXCLR = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_SEND = 2'd3
  } eng_st_e;
endpackage

// File: rtl/mtd_line_bank.sv
module mtd_line_bank #(
  parameter int NLINES = 16,
  parameter int AW     = 16,
  parameter int CW     = 16,
  localparam int LW    = $clog2(NLINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mclr,
  input  logic [LW-1:0]            sw_sel,
  input  logic                     sw_addr_we,
  input  logic                     sw_cnt_we,
  input  logic [mtd_pkg::REG_W-1:0] sw_wdata,
  output logic [AW-1:0]            sw_addr_q,
  output logic [CW-1:0]            sw_cnt_q,
  input  logic [LW-1:0]            eng_idx,
  input  logic                     eng_upd,
  output logic [AW-1:0]            eng_addr_q,
  output logic [CW-1:0]            eng_cnt_q
);
  logic [NLINES-1:0][AW-1:0] a_all;
  logic [NLINES-1:0][CW-1:0] c_all;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [AW-1:0] a_r;
    logic [CW-1:0] c_r;
    logic          sw_hit;
    logic          eng_hit;
    assign sw_hit  = (sw_sel == LW'(g));
    assign eng_hit = eng_upd && (eng_idx == LW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_r <= '0;
        c_r <= '0;
      end else if (mclr) begin
        a_r <= '0;
        c_r <= '0;
      end else begin
        if (sw_addr_we && sw_hit)  a_r <= sw_wdata[AW-1:0];
        else if (eng_hit)          a_r <= a_r + AW'(1);
        if (sw_cnt_we && sw_hit)   c_r <= sw_wdata[CW-1:0];
        else if (eng_hit)          c_r <= c_r + CW'(1);
      end
    end
    assign a_all[g] = a_r;
    assign c_all[g] = c_r;
  end

  assign sw_addr_q  = a_all[sw_sel];
  assign sw_cnt_q   = c_all[sw_sel];
  assign eng_addr_q = a_all[eng_idx];
  assign eng_cnt_q  = c_all[eng_idx];

  // R2: a delivered byte moves the count of its line up by exactly one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    eng_upd && !(sw_cnt_we && sw_sel == eng_idx)
    |=> c_all[$past(eng_idx)] == $past(eng_cnt_q) + CW'(1));
endmodule

// File: rtl/mtd_rr_arb.sv
module mtd_rr_arb #(
  parameter int NLINES = 16,
  localparam int LW    = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NLINES-1:0] req,
  input  logic              take,
  output logic              any,
  output logic [LW-1:0]     idx
);
  logic [LW-1:0] ptr;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 1; i <= NLINES; i++) begin
      int k;
      k = (int'(ptr) + i) % NLINES;
      if (!any && req[k]) begin
        any = 1'b1;
        idx = LW'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= LW'(NLINES - 1);
    else if (clr)  ptr <= LW'(NLINES - 1);
    else if (take) ptr <= idx;
  end

  // R4: with two or more requesters the grant moves off the last winner
  p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
    take && ($countones(req) > 1)
    |=> ($countones(req) < 2) || (idx != $past(idx)));
endmodule

// File: rtl/mtd_fetch_fsm.sv
module mtd_fetch_fsm #(
  parameter int NLINES = 16,
  parameter int AW     = 16,
  parameter int CW     = 16,
  localparam int LW    = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              gnt_any,
  input  logic [LW-1:0]     gnt_idx,
  output logic              arb_take,
  output logic [LW-1:0]     eng_idx,
  output logic              eng_upd,
  input  logic [AW-1:0]     eng_addr_q,
  input  logic [CW-1:0]     eng_cnt_q,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              tx_valid,
  input  logic [NLINES-1:0] tx_ready,
  output logic [LW-1:0]     tx_line,
  output logic [7:0]        tx_data,
  output logic              retire,
  output logic [LW-1:0]     retire_line,
  output logic              nxm_set
);
  import mtd_pkg::*;

  eng_st_e       st;
  logic [LW-1:0] cur;
  logic [AW-1:0] addr_r;
  logic [7:0]    data_r;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx      = eng_cnt_q + CW'(1);
  assign eng_idx     = (st == ST_IDLE) ? gnt_idx : cur;
  assign arb_take    = (st == ST_IDLE) && gnt_any;
  assign retire_line = eng_idx;

  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_addr  = addr_r;
  assign tx_valid      = (st == ST_SEND);
  assign tx_line       = cur;
  assign tx_data       = data_r;

  always_comb begin
    eng_upd = 1'b0;
    retire  = 1'b0;
    nxm_set = 1'b0;
    case (st)
      ST_IDLE: retire = gnt_any && (eng_cnt_q == '0);
      ST_WAIT: if (mem_rsp_valid && mem_rsp_err) begin
        retire  = 1'b1;
        nxm_set = 1'b1;
      end
      ST_SEND: if (tx_ready[cur]) begin
        eng_upd = 1'b1;
        retire  = (cnt_nx == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cur    <= '0;
      addr_r <= '0;
      data_r <= '0;
    end else if (mclr) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (gnt_any && eng_cnt_q != '0) begin
          st     <= ST_REQ;
          cur    <= gnt_idx;
          addr_r <= eng_addr_q;
        end
        ST_REQ:  if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) st <= ST_IDLE;
          else begin
            data_r <= mem_rsp_data;
            st     <= ST_SEND;
          end
        end
        ST_SEND: if (tx_ready[cur]) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: request held with a steady address until accepted
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10: transmit byte held with steady line and data until taken
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    tx_valid && !tx_ready[tx_line]
    |=> tx_valid && $stable(tx_data) && $stable(tx_line));
endmodule

// File: rtl/mux_tx_dma.sv
module mux_tx_dma #(
  parameter int NLINES = 16,
  parameter int AW     = 16,
  parameter int CW     = 16,
  localparam int LW    = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [2:0]        csr_addr,
  input  logic [15:0]       csr_wdata,
  output logic [15:0]       csr_rdata,
  output logic              irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              tx_valid,
  input  logic [NLINES-1:0] tx_ready,
  output logic [LW-1:0]     tx_line,
  output logic [7:0]        tx_data,
  output logic [NLINES-1:0] line_break
);
  import mtd_pkg::*;

  logic              ctrl_we, mclr, ctrl_wr, addr_we, cnt_we, act_we, brk_we;
  logic [LW-1:0]     sel_q;
  logic              ien_q, flag_q, nxm_q;
  logic [NLINES-1:0] active_q, brk_q, set_mask, ret_mask, elig;
  logic [AW-1:0]     sw_addr_q, eng_addr_q;
  logic [CW-1:0]     sw_cnt_q, eng_cnt_q;
  logic [LW-1:0]     gnt_idx, eng_idx, retire_line;
  logic              gnt_any, arb_take, eng_upd, retire, nxm_set;

  assign ctrl_we = csr_we && (csr_addr == OFF_CTRL);
  assign mclr    = ctrl_we && csr_wdata[B_MCLR];
  assign ctrl_wr = ctrl_we && !csr_wdata[B_MCLR];
  assign addr_we = csr_we && (csr_addr == OFF_ADDR);
  assign cnt_we  = csr_we && (csr_addr == OFF_CNT);
  assign act_we  = csr_we && (csr_addr == OFF_ACT);
  assign brk_we  = csr_we && (csr_addr == OFF_BRK);

  assign set_mask = act_we ? csr_wdata[NLINES-1:0] : '0;
  assign ret_mask = retire ? (NLINES'(1) << retire_line) : '0;
  assign elig     = active_q & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      ien_q    <= 1'b0;
      flag_q   <= 1'b0;
      nxm_q    <= 1'b0;
      active_q <= '0;
      brk_q    <= '0;
    end else if (mclr) begin
      sel_q    <= '0;
      ien_q    <= 1'b0;
      flag_q   <= 1'b0;
      nxm_q    <= 1'b0;
      active_q <= '0;
      brk_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        sel_q <= csr_wdata[LW-1:0];
        ien_q <= csr_wdata[B_TXIE];
      end
      if (retire)                           flag_q <= 1'b1;
      else if (ctrl_wr && !csr_wdata[B_TXF]) flag_q <= 1'b0;
      if (nxm_set)                            nxm_q <= 1'b1;
      else if (ctrl_wr && csr_wdata[B_NXCLR]) nxm_q <= 1'b0;
      active_q <= (active_q & ~ret_mask) | set_mask;
      if (brk_we) brk_q <= csr_wdata[NLINES-1:0];
    end
  end

  assign irq        = flag_q && ien_q;
  assign line_break = brk_q;

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      OFF_CTRL: begin
        csr_rdata[B_TXF]   = flag_q;
        csr_rdata[B_TXIE]  = ien_q;
        csr_rdata[B_NXM]   = nxm_q;
        csr_rdata[LW-1:0]  = sel_q;
      end
      OFF_ADDR: csr_rdata[AW-1:0]     = sw_addr_q;
      OFF_CNT:  csr_rdata[CW-1:0]     = sw_cnt_q;
      OFF_ACT:  csr_rdata[NLINES-1:0] = active_q;
      OFF_BRK:  csr_rdata[NLINES-1:0] = brk_q;
      default:  csr_rdata = '0;
    endcase
  end

  mtd_line_bank #(.NLINES(NLINES), .AW(AW), .CW(CW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .mclr       (mclr),
    .sw_sel     (sel_q),
    .sw_addr_we (addr_we),
    .sw_cnt_we  (cnt_we),
    .sw_wdata   (csr_wdata),
    .sw_addr_q  (sw_addr_q),
    .sw_cnt_q   (sw_cnt_q),
    .eng_idx    (eng_idx),
    .eng_upd    (eng_upd),
    .eng_addr_q (eng_addr_q),
    .eng_cnt_q  (eng_cnt_q)
  );

  mtd_rr_arb #(.NLINES(NLINES)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mclr),
    .req   (elig),
    .take  (arb_take),
    .any   (gnt_any),
    .idx   (gnt_idx)
  );

  mtd_fetch_fsm #(.NLINES(NLINES), .AW(AW), .CW(CW)) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .mclr          (mclr),
    .gnt_any       (gnt_any),
    .gnt_idx       (gnt_idx),
    .arb_take      (arb_take),
    .eng_idx       (eng_idx),
    .eng_upd       (eng_upd),
    .eng_addr_q    (eng_addr_q),
    .eng_cnt_q     (eng_cnt_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_line       (tx_line),
    .tx_data       (tx_data),
    .retire        (retire),
    .retire_line   (retire_line),
    .nxm_set       (nxm_set)
  );

  // R2: bytes are only ever offered for a line whose active bit is set
  p_tx_active_r2: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    tx_valid |-> active_q[tx_line]);

  // R2: a retiring line leaves the active mask unless software re-arms it
  p_retire_clear_r2: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    retire && !(act_we && csr_wdata[retire_line])
    |=> !active_q[$past(retire_line)]);

  // R7: an error response leaves the bad-memory flag set
  p_nxm_flag_r7: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    nxm_set |=> nxm_q && flag_q);
endmodule

// File: tb/mux_tx_dma_tb.sv
module mux_tx_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [15:0] csr_wdata = '0;
  logic [15:0] csr_rdata;
  logic        irq;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        tx_valid;
  logic [15:0] txr = '1;
  logic [3:0]  tx_line;
  logic [7:0]  tx_data;
  logic [15:0] line_break;

  int checks = 0;
  int fails = 0;
  int log_n = 0;
  int mreq_n = 0;
  logic       stall = 1'b0;
  logic [3:0] log_line [0:255];
  logic [7:0] log_data [0:255];

  always #2 clk = ~clk;

  mux_tx_dma u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .tx_valid(tx_valid), .tx_ready(txr), .tx_line(tx_line),
    .tx_data(tx_data), .line_break(line_break)
  );

  function automatic logic [7:0] exp_byte(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  // memory model: one-cycle response, error in the top 4 KiB
  initial begin
    logic        hs;
    logic [15:0] ha;
    forever begin
      @(negedge clk);
      hs = mem_req_valid && mem_req_ready;
      ha = mem_req_addr;
      if (hs) mreq_n++;
      @(posedge clk);
      #1;
      mem_rsp_valid = hs;
      mem_rsp_data  = exp_byte(ha);
      mem_rsp_err   = (ha[15:12] == 4'hF);
      mem_req_ready = !stall;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (tx_valid && txr[tx_line] && log_n < 256) begin
        log_line[log_n] = tx_line;
        log_data[log_n] = tx_data;
        log_n++;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [2:0] a, output logic [15:0] v);
    @(posedge clk); #1;
    csr_addr = a;
    @(negedge clk);
    v = csr_rdata;
  endtask

  task automatic program_line(input logic [3:0] ln, input logic [15:0] a,
                              input logic [15:0] cnt);
    csr_wr(3'd0, 16'hA000 | {12'h0, ln});
    csr_wr(3'd1, a);
    csr_wr(3'd2, cnt);
  endtask

  task automatic wait_clear(input logic [15:0] mask);
    logic [15:0] v;
    for (int i = 0; i < 3000; i++) begin
      csr_rd(3'd3, v);
      if ((v & mask) == 16'h0) break;
    end
  endtask

  // line[27:24], start address[23:8], byte count[7:0]
  localparam logic [27:0] VEC [6] = '{
    {4'd0,  16'h0100, 8'd1},
    {4'd15, 16'h01FE, 8'd4},
    {4'd6,  16'h2000, 8'd9},
    {4'd9,  16'h00FF, 8'd3},
    {4'd3,  16'h7FF0, 8'd16},
    {4'd12, 16'h0EFF, 8'd2}
  };

  initial begin
    logic [15:0] v;
    int          base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state (R1, R8)
    @(negedge clk);
    check("R1 irq after reset", irq, 0);
    check("R1 mem_req_valid after reset", mem_req_valid, 0);
    check("R1 tx_valid after reset", tx_valid, 0);
    check("R9 line_break after reset", line_break, 0);
    csr_rd(3'd0, v); check("R1 ctrl after reset", v, 0);
    csr_rd(3'd3, v); check("R1 active after reset", v, 0);

    // banked window (R1)
    program_line(4'd4, 16'h1234, 16'h0000);
    program_line(4'd5, 16'h5678, 16'h0000);
    csr_wr(3'd0, 16'hA004);
    csr_rd(3'd1, v); check("R1 line 4 address", v, 16'h1234);
    csr_wr(3'd0, 16'hA005);
    csr_rd(3'd1, v); check("R1 line 5 address", v, 16'h5678);

    // table-driven transfers (R2, R6)
    for (int k = 0; k < 6; k++) begin
      logic [3:0]  ln;
      logic [15:0] sa;
      int          n;
      int          bad;
      ln = VEC[k][27:24];
      sa = VEC[k][23:8];
      n  = int'(VEC[k][7:0]);
      log_n = 0;
      program_line(ln, sa, 16'(-n));
      csr_wr(3'd3, 16'(1) << ln);
      wait_clear(16'(1) << ln);
      repeat (2) @(negedge clk);
      check("R2 bytes sent", log_n, n);
      bad = 0;
      for (int i = 0; i < n; i++)
        if (log_line[i] != ln || log_data[i] != exp_byte(sa + 16'(i))) bad++;
      check("R2 byte line/data mismatches", bad, 0);
      csr_rd(3'd1, v); check("R2 address one past last", v, sa + 16'(n));
      csr_rd(3'd2, v); check("R2 count at zero", v, 0);
      check("R6 irq on retire", irq, 1);
      csr_wr(3'd0, 16'hA000 | {12'h0, ln});
      csr_rd(3'd0, v); check("R6 flag kept by writing 1", v[15], 1);
      csr_wr(3'd0, 16'h2000 | {12'h0, ln});
      @(negedge clk);
      check("R6 irq cleared by writing 0", irq, 0);
    end

    // zero count at grant (R11)
    log_n = 0;
    program_line(4'd8, 16'h0400, 16'h0000);
    base = mreq_n;
    csr_wr(3'd3, 16'h0100);
    wait_clear(16'h0100);
    csr_rd(3'd3, v); check("R11 zero-count line retired", v[8], 0);
    check("R11 no memory request", mreq_n - base, 0);
    check("R11 no byte sent", log_n, 0);
    csr_rd(3'd0, v); check("R11 flag set", v[15], 1);
    csr_wr(3'd0, 16'h2008);

    // memory error (R7)
    log_n = 0;
    program_line(4'd7, 16'hF010, 16'hFFFD);
    csr_wr(3'd3, 16'h0080);
    wait_clear(16'h0080);
    csr_rd(3'd0, v);
    check("R7 bad-memory flag", v[10], 1);
    check("R7 transmit flag on error", v[15], 1);
    check("R7 no byte sent", log_n, 0);
    csr_rd(3'd1, v); check("R7 address kept", v, 16'hF010);
    csr_rd(3'd2, v); check("R7 count kept", v, 16'hFFFD);
    csr_wr(3'd0, 16'hA107);
    csr_rd(3'd0, v); check("R7 bit 8 clears bad-memory flag", v[10], 0);
    csr_wr(3'd0, 16'h2007);

    // abort while parked on the request (R5, R10)
    log_n = 0;
    stall = 1'b1;
    program_line(4'd10, 16'h3000, 16'(-20));
    csr_wr(3'd3, 16'h0400);
    repeat (5) @(negedge clk);
    check("R10 request held while not ready", mem_req_valid, 1);
    check("R10 request address", mem_req_addr, 16'h3000);
    csr_wr(3'd2, 16'hFFFF);
    @(negedge clk);
    check("R10 request address still stable", mem_req_addr, 16'h3000);
    stall = 1'b0;
    wait_clear(16'h0400);
    repeat (2) @(negedge clk);
    check("R5 exactly one byte after abort", log_n, 1);
    check("R5 aborted byte value", log_data[0], exp_byte(16'h3000));
    csr_rd(3'd1, v); check("R5 address after abort", v, 16'h3001);
    csr_wr(3'd0, 16'h200A);

    // back-pressure on one line; OR-only active writes (R3, R4)
    log_n = 0;
    txr[1] = 1'b0;
    program_line(4'd1, 16'h0500, 16'(-2));
    program_line(4'd3, 16'h0600, 16'(-8));
    csr_wr(3'd3, 16'h0002);
    csr_wr(3'd3, 16'h0008);
    csr_rd(3'd3, v); check("R3 both bits set by OR writes", v & 16'h000A, 16'h000A);
    wait_clear(16'h0008);
    repeat (2) @(negedge clk);
    check("R4 blocked line sends nothing, other line finishes", log_n, 8);
    csr_rd(3'd3, v); check("R4 blocked line still active", v, 16'h0002);
    @(posedge clk); #1 txr[1] = 1'b1;
    wait_clear(16'h0002);
    repeat (2) @(negedge clk);
    check("R4 released line finishes", log_n, 10);
    csr_wr(3'd0, 16'h2001);

    // break mask (R9)
    csr_wr(3'd4, 16'h8421);
    @(negedge clk);
    check("R9 line_break drives", line_break, 16'h8421);
    csr_rd(3'd4, v); check("R9 break readback", v, 16'h8421);

    // master clear (R8)
    csr_wr(3'd0, 16'h0800);
    @(negedge clk);
    check("R8 break cleared", line_break, 0);
    csr_rd(3'd0, v); check("R8 ctrl cleared", v, 0);
    csr_wr(3'd0, 16'h2007);
    csr_rd(3'd1, v); check("R8 address cleared", v, 0);
    csr_rd(3'd2, v); check("R8 count cleared", v, 0);
    csr_wr(3'd0, 16'h0800);

    // round-robin after master clear: 2,5,2,5,2,5 (R4)
    log_n = 0;
    program_line(4'd2, 16'h0A00, 16'(-3));
    program_line(4'd5, 16'h0B00, 16'(-3));
    csr_wr(3'd3, 16'h0024);
    wait_clear(16'h0024);
    repeat (2) @(negedge clk);
    check("R4 round-robin byte total", log_n, 6);
    for (int i = 0; i < 6; i++)
      check("R4 round-robin order", log_line[i], (i % 2 == 0) ? 2 : 5);

    finish_run();
  end
endmodule